// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block turns a stream of interrupt events into fixed-size records in a circular buffer held in system memory. Each accepted event is packed into a 16-byte record of four 32-bit words. The record is written through a simple word-wide memory write port at the ring base plus the current write pointer. The write pointer then moves forward one record and wraps at the configured ring size. Software consumes records and reports its progress by writing the read pointer register. The block compares the two pointers to decide whether the ring is full.

When the ring fills, one of two policies applies. With overflow handling off, the block stops accepting events until software frees space. With overflow handling on, the block keeps writing over the oldest record and sets a sticky flag carried in bit 0 of the write-pointer value. To recover, the consumer moves its read pointer to one record beyond the write pointer, then clears the flag through a dedicated control bit. After every record, and optionally after every overflowing record, the block can mirror the write-pointer value to a writeback address in memory. The consumer can then poll memory instead of the register port.

Top module: `irq_ring_writer`

## Requirements
- R1: After reset, ev_ready, mem_we and wb_we are low, and every register reads back as zero, including the write pointer, the read pointer and the status word.
- R2: ev_ready is high only when the global enable (register 0 bit 0) and the ring enable (register 1 bit 0) are both set and no record is in progress.
- R3: An accepted event produces exactly four consecutive memory word writes at base*256 + wptr + 0, 4, 8 and 12. The words are: word 0 = {24'b0, source id}; word 1 = {4'b0, 28-bit source data}; word 2 = {16'b0, vmid, ring id}; word 3 = 0.
- R4: After the fourth word, the write pointer advances by 16, wrapped with mask (4 << size) - 1. Size is the log2 of the ring length in words, held in register 1 bits [5:1].
- R5: The ring is full when (wptr + 16) masked equals the masked read pointer. While the ring is full and overflow handling (register 1 bit 16) is off, ev_ready stays low and nothing is written.
- R6: When overflow handling is on and an event is accepted while the ring is full, the record is still written and bit 0 of the write-pointer readback (register 4) becomes 1. The flag stays set until it is cleared.
- R7: A register 1 write with bit 17 set clears the overflow flag. Bit 17 always reads back as 0. A flag set in the same cycle as a clear wins.
- R8: When writeback is enabled (register 1 bit 18), each record is followed by one writeback write. Its address is {wb_hi[7:0], wb_lo[31:2], 2'b00}, where register 5 is the low part and register 6 the high part, limited to 8 bits. Its data is the register 4 readback value. When writeback is disabled, no writeback write occurs.
- R9: Software writes to the read pointer (register 3) and write pointer (register 4) replace them, with the low four bits forced to zero. Writing zero to both resets the ring. A recovery read pointer of wptr + 16 is accepted as written.
- R10: Status register 7 bit 0 (busy) is high from the cycle after an event is accepted until its record and writeback slot have completed.
- R11: The ring base (register 2) holds the address shifted right by 8. Register 1 reads back its enable, size, overflow-enable and writeback-enable fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event will be taken this cycle |
| ev_src | input | 8 | Source id |
| ev_data | input | 28 | Source data |
| ev_ring | input | 8 | Ring id |
| ev_vmid | input | 8 | Virtual machine id |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| mem_we | output | 1 | Ring word write strobe |
| mem_addr | output | 40 | Ring word byte address |
| mem_wdata | output | 32 | Ring word data |
| wb_we | output | 1 | Pointer writeback strobe |
| wb_addr | output | 40 | Writeback byte address |
| wb_data | output | 32 | Writeback data (write-pointer value with flag) |

## Verification
Some properties are checked on every cycle: the enable gating and full-ring stall of ev_ready, the unbroken four-word burst, the 16-byte masked pointer step, the stickiness and clearing of the overflow flag, the writeback slot that follows each record, and busy covering every write. Only the bench scenarios can show several things: the record contents and addresses, the wrap of the write pointer at the ring size, the overwrite-and-flag sequence with the consumer's wptr + 16 recovery, and the register readback encodings.

// File: rtl/irq_ring_pkg.sv
package irq_ring_pkg;

    localparam int unsigned REC_WORDS  = 4;
    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned REC_BYTES  = REC_WORDS * WORD_BYTES;
    localparam int unsigned BASE_SHIFT = 8;
    localparam int unsigned REG_AW     = 3;
    localparam int unsigned SIZE_W     = 5;

    // register indices
    localparam logic [REG_AW-1:0] RA_MAIN   = 3'd0;
    localparam logic [REG_AW-1:0] RA_CTL    = 3'd1;
    localparam logic [REG_AW-1:0] RA_BASE   = 3'd2;
    localparam logic [REG_AW-1:0] RA_RPTR   = 3'd3;
    localparam logic [REG_AW-1:0] RA_WPTR   = 3'd4;
    localparam logic [REG_AW-1:0] RA_WBLO   = 3'd5;
    localparam logic [REG_AW-1:0] RA_WBHI   = 3'd6;
    localparam logic [REG_AW-1:0] RA_STATUS = 3'd7;

    // ring control bit positions
    localparam int unsigned CTL_RING_EN  = 0;
    localparam int unsigned CTL_SIZE_LSB = 1;
    localparam int unsigned CTL_OVF_EN   = 16;
    localparam int unsigned CTL_OVF_CLR  = 17;
    localparam int unsigned CTL_WB_EN    = 18;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_WBACK = 2'd2
    } ring_state_e;

    typedef struct packed {
        logic [7:0]  src;
        logic [27:0] data;
        logic [7:0]  ring;
        logic [7:0]  vmid;
    } ring_event_t;

endpackage

// File: rtl/irq_ring_regs.sv
module irq_ring_regs
    import irq_ring_pkg::*;
#(
    parameter int unsigned PTR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              busy,
    input  logic [PTR_W-1:0]  wptr,
    input  logic              ovf,
    output logic              glob_en,
    output logic              ring_en,
    output logic [SIZE_W-1:0] ring_size,
    output logic              ovf_en,
    output logic              wb_en,
    output logic              ovf_clr,
    output logic [31:0]       base_addr,
    output logic [PTR_W-1:0]  rptr,
    output logic [29:0]       wb_lo,
    output logic [7:0]        wb_hi,
    output logic              sw_wptr_wr,
    output logic [PTR_W-1:0]  sw_wptr_val
);

    localparam int unsigned ALIGN_W = $clog2(REC_BYTES);

    typedef struct packed {
        logic              glob_en;
        logic              ring_en;
        logic [SIZE_W-1:0] size;
        logic              ovf_en;
        logic              wb_en;
        logic [31:0]       base;
        logic [PTR_W-1:0]  rptr;
        logic [29:0]       wb_lo;
        logic [7:0]        wb_hi;
    } regs_t;

    regs_t regs_q, regs_d;

    always_comb begin
        regs_d = regs_q;
        if (cfg_wr) begin
            case (cfg_addr)
                RA_MAIN: regs_d.glob_en = cfg_wdata[0];
                RA_CTL: begin
                    regs_d.ring_en = cfg_wdata[CTL_RING_EN];
                    regs_d.size    = cfg_wdata[CTL_SIZE_LSB +: SIZE_W];
                    regs_d.ovf_en  = cfg_wdata[CTL_OVF_EN];
                    regs_d.wb_en   = cfg_wdata[CTL_WB_EN];
                end
                RA_BASE: regs_d.base  = cfg_wdata;
                RA_RPTR: regs_d.rptr  = {cfg_wdata[PTR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
                RA_WBLO: regs_d.wb_lo = cfg_wdata[31:2];
                RA_WBHI: regs_d.wb_hi = cfg_wdata[7:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            RA_MAIN: cfg_rdata[0] = regs_q.glob_en;
            RA_CTL: begin
                cfg_rdata[CTL_RING_EN]               = regs_q.ring_en;
                cfg_rdata[CTL_SIZE_LSB +: SIZE_W]    = regs_q.size;
                cfg_rdata[CTL_OVF_EN]                = regs_q.ovf_en;
                cfg_rdata[CTL_WB_EN]                 = regs_q.wb_en;
            end
            RA_BASE: cfg_rdata = regs_q.base;
            RA_RPTR: cfg_rdata[PTR_W-1:0] = regs_q.rptr;
            RA_WPTR: begin
                cfg_rdata[PTR_W-1:0] = wptr;
                cfg_rdata[0]         = ovf;
            end
            RA_WBLO: cfg_rdata[31:2] = regs_q.wb_lo;
            RA_WBHI: cfg_rdata[7:0]  = regs_q.wb_hi;
            RA_STATUS: cfg_rdata[0]  = busy;
            default: ;
        endcase
    end

    assign glob_en     = regs_q.glob_en;
    assign ring_en     = regs_q.ring_en;
    assign ring_size   = regs_q.size;
    assign ovf_en      = regs_q.ovf_en;
    assign wb_en       = regs_q.wb_en;
    assign base_addr   = regs_q.base;
    assign rptr        = regs_q.rptr;
    assign wb_lo       = regs_q.wb_lo;
    assign wb_hi       = regs_q.wb_hi;
    assign ovf_clr     = cfg_wr && (cfg_addr == RA_CTL) && cfg_wdata[CTL_OVF_CLR];
    assign sw_wptr_wr  = cfg_wr && (cfg_addr == RA_WPTR);
    assign sw_wptr_val = cfg_wdata[PTR_W-1:0];

endmodule

// File: rtl/irq_ring_ptr.sv
module irq_ring_ptr
    import irq_ring_pkg::*;
#(
    parameter int unsigned PTR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SIZE_W-1:0] ring_size,
    input  logic [PTR_W-1:0]  rptr,
    input  logic              sw_wptr_wr,
    input  logic [PTR_W-1:0]  sw_wptr_val,
    input  logic              adv,
    input  logic              ovf_set,
    input  logic              ovf_clr,
    output logic [PTR_W-1:0]  wptr,
    output logic              ovf,
    output logic [PTR_W-1:0]  mask,
    output logic              full
);

    localparam logic [PTR_W-1:0] REC_STEP   = PTR_W'(REC_BYTES);
    localparam logic [PTR_W-1:0] WORD_STEP  = PTR_W'(WORD_BYTES);
    localparam logic [PTR_W-1:0] ALIGN_MASK = ~PTR_W'(REC_BYTES - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic             ovf;
    } ptr_t;

    ptr_t ptr_q, ptr_d;
    logic [PTR_W-1:0] wptr_next;

    // ring bytes = 4 << size; a shift past the width gives the full range
    assign mask      = (WORD_STEP << ring_size) - PTR_W'(1);
    assign wptr_next = (ptr_q.wptr + REC_STEP) & mask;
    assign full      = (wptr_next == (rptr & mask));

    always_comb begin
        ptr_d = ptr_q;
        if (sw_wptr_wr)  ptr_d.wptr = sw_wptr_val & mask & ALIGN_MASK;
        else if (adv)    ptr_d.wptr = wptr_next;
        if (ovf_set)     ptr_d.ovf = 1'b1;
        else if (ovf_clr) ptr_d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign wptr = ptr_q.wptr;
    assign ovf  = ptr_q.ovf;

endmodule

// File: rtl/irq_ring_pack.sv
module irq_ring_pack
    import irq_ring_pkg::*;
#(
    parameter int unsigned PTR_W  = 16,
    parameter int unsigned ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              ovf_en,
    input  logic              full,
    input  logic              wb_en,
    input  logic              ev_valid,
    input  ring_event_t       ev,
    input  logic [31:0]       base_addr,
    input  logic [PTR_W-1:0]  wptr,
    input  logic              ovf,
    input  logic [29:0]       wb_lo,
    input  logic [7:0]        wb_hi,
    output logic              ev_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic              wb_we,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [31:0]       wb_data,
    output logic              adv,
    output logic              ovf_set,
    output logic              busy
);

    localparam int unsigned WC_W = $clog2(REC_WORDS);
    localparam logic [WC_W-1:0] WC_LAST = WC_W'(REC_WORDS - 1);

    typedef struct packed {
        ring_state_e st;
        logic [WC_W-1:0] wcnt;
        ring_event_t     rec;
    } pack_t;

    pack_t pk_q, pk_d;

    assign ev_ready = enable && (pk_q.st == ST_IDLE) && (!full || ovf_en);

    always_comb begin
        pk_d    = pk_q;
        adv     = 1'b0;
        ovf_set = 1'b0;
        case (pk_q.st)
            ST_IDLE: begin
                if (ev_valid && ev_ready) begin
                    pk_d.rec  = ev;
                    pk_d.wcnt = '0;
                    pk_d.st   = ST_WRITE;
                    ovf_set   = full;
                end
            end
            ST_WRITE: begin
                pk_d.wcnt = pk_q.wcnt + WC_W'(1);
                if (pk_q.wcnt == WC_LAST) begin
                    adv     = 1'b1;
                    pk_d.st = ST_WBACK;
                end
            end
            ST_WBACK: pk_d.st = ST_IDLE;
            default:  pk_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    always_comb begin
        case (pk_q.wcnt)
            2'd0:    mem_wdata = {24'b0, pk_q.rec.src};
            2'd1:    mem_wdata = {4'b0, pk_q.rec.data};
            2'd2:    mem_wdata = {16'b0, pk_q.rec.vmid, pk_q.rec.ring};
            default: mem_wdata = '0;
        endcase
    end

    assign mem_we   = (pk_q.st == ST_WRITE);
    assign mem_addr = ADDR_W'({base_addr, {BASE_SHIFT{1'b0}}})
                    + ADDR_W'(wptr)
                    + ADDR_W'({pk_q.wcnt, 2'b00});

    assign wb_we   = (pk_q.st == ST_WBACK) && wb_en;
    assign wb_addr = ADDR_W'({wb_hi, wb_lo, 2'b00});
    always_comb begin
        wb_data             = '0;
        wb_data[PTR_W-1:0]  = wptr;
        wb_data[0]          = ovf;
    end

    assign busy = (pk_q.st != ST_IDLE);

endmodule

// File: rtl/irq_ring_writer.sv
module irq_ring_writer
    import irq_ring_pkg::*;
#(
    parameter int unsigned PTR_W  = 16,
    parameter int unsigned ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic [7:0]        ev_src,
    input  logic [27:0]       ev_data,
    input  logic [7:0]        ev_ring,
    input  logic [7:0]        ev_vmid,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic              wb_we,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [31:0]       wb_data
);

    logic              glob_en, ring_en, ovf_en, wb_en, ovf_clr;
    logic [SIZE_W-1:0] ring_size;
    logic [31:0]       base_addr;
    logic [PTR_W-1:0]  rptr, wptr, mask, sw_wptr_val;
    logic [29:0]       wb_lo;
    logic [7:0]        wb_hi;
    logic              sw_wptr_wr, ovf, full, adv, ovf_set, busy;
    ring_event_t       ev_pkt;

    assign ev_pkt = '{src: ev_src, data: ev_data, ring: ev_ring, vmid: ev_vmid};

    irq_ring_regs #(.PTR_W(PTR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .busy(busy), .wptr(wptr), .ovf(ovf),
        .glob_en(glob_en), .ring_en(ring_en), .ring_size(ring_size),
        .ovf_en(ovf_en), .wb_en(wb_en), .ovf_clr(ovf_clr),
        .base_addr(base_addr), .rptr(rptr), .wb_lo(wb_lo), .wb_hi(wb_hi),
        .sw_wptr_wr(sw_wptr_wr), .sw_wptr_val(sw_wptr_val)
    );

    irq_ring_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .ring_size(ring_size), .rptr(rptr),
        .sw_wptr_wr(sw_wptr_wr), .sw_wptr_val(sw_wptr_val),
        .adv(adv), .ovf_set(ovf_set), .ovf_clr(ovf_clr),
        .wptr(wptr), .ovf(ovf), .mask(mask), .full(full)
    );

    irq_ring_pack #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_pack (
        .clk(clk), .rst_n(rst_n),
        .enable(glob_en && ring_en), .ovf_en(ovf_en), .full(full), .wb_en(wb_en),
        .ev_valid(ev_valid), .ev(ev_pkt),
        .base_addr(base_addr), .wptr(wptr), .ovf(ovf), .wb_lo(wb_lo), .wb_hi(wb_hi),
        .ev_ready(ev_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .wb_we(wb_we), .wb_addr(wb_addr), .wb_data(wb_data),
        .adv(adv), .ovf_set(ovf_set), .busy(busy)
    );

endmodule

// File: rtl/irq_ring_writer_chk.sv
module irq_ring_writer_chk #(
    parameter int unsigned PTR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ev_ready,
    input logic             glob_en,
    input logic             ring_en,
    input logic             ovf_en,
    input logic             wb_en,
    input logic             full,
    input logic             mem_we,
    input logic             wb_we,
    input logic             adv,
    input logic             sw_wptr_wr,
    input logic             ovf,
    input logic             ovf_set,
    input logic             ovf_clr,
    input logic             busy,
    input logic [PTR_W-1:0] wptr,
    input logic [PTR_W-1:0] mask
);

    a_r2_ready_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !(glob_en && ring_en) |-> !ev_ready);

    a_r5_stall_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !ovf_en) |-> !ev_ready);

    a_r3_four_word_burst: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |=> mem_we ##1 mem_we ##1 mem_we ##1 !mem_we);

    a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !sw_wptr_wr) |=> (wptr == (($past(wptr) + PTR_W'(16)) & $past(mask))));

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

    a_r7_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !ovf_set) |=> !ovf);

    a_r8_wb_follows_record: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (wb_we == $past(wb_en)));

    a_r10_busy_covers_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || wb_we) |-> busy);

endmodule

bind irq_ring_writer irq_ring_writer_chk #(.PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_ready(ev_ready),
    .glob_en(glob_en), .ring_en(ring_en), .ovf_en(ovf_en), .wb_en(wb_en),
    .full(full), .mem_we(mem_we), .wb_we(wb_we), .adv(adv),
    .sw_wptr_wr(sw_wptr_wr), .ovf(ovf), .ovf_set(ovf_set), .ovf_clr(ovf_clr),
    .busy(busy), .wptr(wptr), .mask(mask)
);

// File: tb/irq_ring_writer_tb_top.sv
module irq_ring_writer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [39:0] BASE_ADDR = 40'h00_0001_2300;
    localparam logic [39:0] WB_ADDR   = 40'hAB_0000_1000;
    localparam logic [31:0] CTL_BASE  = 32'h0000_0009;   // ring on, size 4 (64 bytes)
    localparam logic [31:0] CTL_WB    = 32'h0004_0000;
    localparam logic [31:0] CTL_OVF   = 32'h0001_0000;
    localparam logic [31:0] CTL_CLR   = 32'h0002_0000;
    localparam int NVEC = 6;
    // src, data, ring, vmid, expected word 1
    localparam logic [83:0] VEC [NVEC] = '{
        {8'h01, 28'h0000001, 8'h00, 8'h00, 32'h0000_0001},
        {8'hFF, 28'h1234567, 8'h05, 8'h0A, 32'h0123_4567},
        {8'h3C, 28'hFFFFFFF, 8'hFF, 8'hFF, 32'h0FFF_FFFF},
        {8'h80, 28'h8000000, 8'h12, 8'h34, 32'h0800_0000},
        {8'h00, 28'h0000000, 8'h00, 8'h01, 32'h0000_0000},
        {8'h5A, 28'hA5A5A5A, 8'h77, 8'h88, 32'h0A5A_5A5A}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic        ev_ready;
    logic [7:0]  ev_src = '0, ev_ring = '0, ev_vmid = '0;
    logic [27:0] ev_data = '0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0, cfg_rdata;
    logic        mem_we, wb_we;
    logic [39:0] mem_addr, wb_addr;
    logic [31:0] mem_wdata, wb_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [39:0] mlog_a [256];
    logic [31:0] mlog_d [256];
    logic [31:0] wlog_d [64];
    logic [39:0] wlog_a [64];
    int mcnt = 0;
    int wcnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_ring_writer dut_i (
        .clk(clk), .rst_n(rst_n),
        .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_src(ev_src), .ev_data(ev_data), .ev_ring(ev_ring), .ev_vmid(ev_vmid),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .wb_we(wb_we), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    always @(negedge clk) begin
        if (mem_we && mcnt < 256) begin
            mlog_a[mcnt] = mem_addr;
            mlog_d[mcnt] = mem_wdata;
            mcnt = mcnt + 1;
        end
        if (wb_we && wcnt < 64) begin
            wlog_a[wcnt] = wb_addr;
            wlog_d[wcnt] = wb_data;
            wcnt = wcnt + 1;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic send_event(input logic [7:0] s, input logic [27:0] dt,
                              input logic [7:0] r, input logic [7:0] v);
        @(negedge clk);
        ev_src = s; ev_data = dt; ev_ring = r; ev_vmid = v; ev_valid = 1'b1;
        for (int n = 0; n < 20 && !ev_ready; n++) @(negedge clk);
        @(negedge clk);
        ev_valid = 1'b0;
        repeat (7) @(negedge clk);
    endtask

    initial begin
        logic [31:0] rd;
        int m0, w0;
        logic [15:0] wp;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 ev_ready", {63'b0, ev_ready}, 64'd0);
        check("R1 mem_we", {63'b0, mem_we}, 64'd0);
        check("R1 wb_we", {63'b0, wb_we}, 64'd0);
        rst_n = 1'b1;
        cfg_read(3'd4, rd); check("R1 wptr", {32'b0, rd}, 64'd0);
        cfg_read(3'd3, rd); check("R1 rptr", {32'b0, rd}, 64'd0);
        cfg_read(3'd1, rd); check("R1 ctl", {32'b0, rd}, 64'd0);
        cfg_read(3'd7, rd); check("R1 status", {32'b0, rd}, 64'd0);

        // R2: global enable alone is not enough
        cfg_write(3'd0, 32'h1);
        cfg_read(3'd0, rd);
        check("R2 ready with ring off", {63'b0, ev_ready}, 64'd0);
        cfg_write(3'd2, 32'(BASE_ADDR >> 8));
        cfg_write(3'd5, 32'h0000_1003);
        cfg_write(3'd6, 32'h0000_01AB);
        cfg_write(3'd1, CTL_BASE | CTL_WB);
        cfg_read(3'd6, rd); check("R8 wb_hi limited", {32'b0, rd}, 64'h0000_00AB);
        cfg_read(3'd2, rd); check("R11 base", {32'b0, rd}, 64'h0000_0123);
        cfg_read(3'd1, rd); check("R11 ctl", {32'b0, rd}, {32'b0, CTL_BASE | CTL_WB});
        check("R2 ready enabled", {63'b0, ev_ready}, 64'd1);

        // R3/R4/R8: table walk, consumer keeps up, ring wraps after 4 records
        for (int i = 0; i < NVEC; i++) begin
            wp = 16'((i * 16) % 64);
            m0 = mcnt; w0 = wcnt;
            send_event(VEC[i][83:76], VEC[i][75:48], VEC[i][47:40], VEC[i][39:32]);
            check("R3 word count", 64'(mcnt - m0), 64'd4);
            for (int k = 0; k < 4; k++)
                check("R3 addr", {24'b0, mlog_a[m0+k]}, {24'b0, BASE_ADDR + 40'(wp) + 40'(4*k)});
            check("R3 word0", {32'b0, mlog_d[m0]},   {56'b0, VEC[i][83:76]});
            check("R3 word1", {32'b0, mlog_d[m0+1]}, {32'b0, VEC[i][31:0]});
            check("R3 word2", {32'b0, mlog_d[m0+2]}, {48'b0, VEC[i][39:32], VEC[i][47:40]});
            check("R3 word3", {32'b0, mlog_d[m0+3]}, 64'd0);
            cfg_read(3'd4, rd);
            check("R4 wptr wrap", {32'b0, rd}, 64'(((i + 1) * 16) % 64));
            check("R8 wb count", 64'(wcnt - w0), 64'd1);
            check("R8 wb data", {32'b0, wlog_d[w0]}, 64'(((i + 1) * 16) % 64));
            check("R8 wb addr", {24'b0, wlog_a[w0]}, {24'b0, WB_ADDR});
            cfg_write(3'd3, rd);
        end

        // R5: fill without consumer: wptr 0x20 -> 0x10, rptr 0x20 -> full
        for (int i = 0; i < 3; i++) send_event(8'h10 + 8'(i), 28'h0, 8'h0, 8'h0);
        cfg_read(3'd4, rd); check("R5 wptr before full", {32'b0, rd}, 64'h10);
        check("R5 stalled when full", {63'b0, ev_ready}, 64'd0);
        m0 = mcnt;
        @(negedge clk); ev_valid = 1'b1;
        repeat (6) @(negedge clk);
        ev_valid = 1'b0;
        check("R5 no write while stalled", 64'(mcnt - m0), 64'd0);

        // R6: overflow handling on: record overwrites, flag in bit 0
        cfg_write(3'd1, CTL_BASE | CTL_WB | CTL_OVF);
        check("R6 ready with overflow on", {63'b0, ev_ready}, 64'd1);
        m0 = mcnt; w0 = wcnt;
        send_event(8'hEE, 28'h0ABCDEF, 8'h01, 8'h02);
        check("R6 record written", 64'(mcnt - m0), 64'd4);
        check("R6 record addr", {24'b0, mlog_a[m0]}, {24'b0, BASE_ADDR + 40'h10});
        cfg_read(3'd4, rd); check("R6 flag in wptr", {32'b0, rd}, 64'h21);
        check("R8 wb carries flag", {32'b0, wlog_d[w0]}, 64'h21);

        // R9: recovery read pointer = wptr + 16
        cfg_write(3'd3, 32'h30);
        cfg_read(3'd3, rd); check("R9 recovery rptr", {32'b0, rd}, 64'h30);
        cfg_write(3'd1, CTL_BASE | CTL_WB);
        check("R5 full after recovery", {63'b0, ev_ready}, 64'd0);
        cfg_write(3'd3, 32'h00);
        check("R5 space after consume", {63'b0, ev_ready}, 64'd1);
        cfg_read(3'd4, rd); check("R6 flag sticky", {32'b0, rd}, 64'h21);

        // R7: clear through control bit
        cfg_write(3'd1, CTL_BASE | CTL_WB | CTL_CLR);
        cfg_read(3'd4, rd); check("R7 flag cleared", {32'b0, rd}, 64'h20);
        cfg_read(3'd1, rd); check("R7 clear bit reads 0", {32'b0, rd}, {32'b0, CTL_BASE | CTL_WB});

        // R8 writeback off, R10 busy during record
        cfg_write(3'd1, CTL_BASE);
        w0 = wcnt; m0 = mcnt;
        @(negedge clk);
        cfg_addr = 3'd7;
        ev_src = 8'h42; ev_data = 28'h1; ev_ring = 8'h0; ev_vmid = 8'h0; ev_valid = 1'b1;
        #1 check("R10 idle before accept", {32'b0, cfg_rdata}, 64'd0);
        @(negedge clk);
        ev_valid = 1'b0;
        #1 check("R10 busy after accept", {32'b0, cfg_rdata}, 64'd1);
        repeat (7) @(negedge clk);
        #1 check("R10 idle after record", {32'b0, cfg_rdata}, 64'd0);
        check("R8 no wb when disabled", 64'(wcnt - w0), 64'd0);
        check("R3 record with wb off", 64'(mcnt - m0), 64'd4);

        // R9 pointer reset while disabled, R2 ready drops
        cfg_write(3'd0, 32'h0);
        check("R2 ready global off", {63'b0, ev_ready}, 64'd0);
        cfg_write(3'd1, 32'h0);
        cfg_write(3'd3, 32'h0);
        cfg_write(3'd4, 32'h0);
        cfg_read(3'd4, rd); check("R9 wptr reset", {32'b0, rd}, 64'd0);
        cfg_read(3'd3, rd); check("R9 rptr reset", {32'b0, rd}, 64'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule